// File: doc/BRIEF.md
# DMA Handshake Ready and Block Interrupt Generator

This block turns the fill counts of a UART's transmit and receive FIFOs into the two active-low handshake lines that a DMA engine watches, plus a transmit and a receive interrupt request. The FIFOs, the serial engines and the register decode stay outside. The block reads their occupancy counts, a FIFO-enable bit, a handshake-mode bit and the programmed receive trigger level, and it registers every output on the system clock.

Single-character mode requests one transfer at a time. The transmit line asks for data whenever any slot is free, and the receive line asks for service whenever any character is waiting. Block mode fills and drains in bursts. The transmit request fires only when the FIFO has fully drained. The transmit ready line then stays low until the FIFO is full. The receive side asserts at the trigger level and keeps asserting while the FIFO fills beyond that level. Clearing the FIFO-enable bit forces single-character behaviour with a one-entry depth, whatever the mode bit says.

There is no data stream through this block, so none of its pins uses a valid/ready handshake. Every pin is a plain level-sensitive control or status signal. No back-pressure rules apply.

Top module: `dma_ready_gen`

## Requirements
- R1: In single-character mode, tx_ready_n is low exactly when tx_level is below the effective depth, and tx_irq is its complement. The effective depth is DEPTH when fifo_en=1 and 1 when fifo_en=0.
- R2: In single-character mode, rx_ready_n is low exactly when rx_level is nonzero, and rx_irq is its complement.
- R3: In block mode, tx_irq is high exactly when tx_level is 0.
- R4: In block mode, tx_ready_n goes low when tx_level is 0 and goes high when tx_level is at least DEPTH. For any level in between it keeps its previous value.
- R5: In block mode, rx_ready_n is low and rx_irq is high exactly when rx_level is at or above the effective trigger. This includes every level past the trigger up to a full FIFO. Below the trigger, rx_ready_n is high and rx_irq is low.
- R6: A trigger value of 0 is treated as 1, and a trigger value above DEPTH is treated as DEPTH.
- R7: With fifo_en=0, the block uses single-character rules with an effective depth of 1, regardless of mode_block.
- R8: Every output reflects the inputs sampled at the preceding rising clock edge, which is one cycle of latency.
- R9: The reset rst_n is synchronous and active low. While it is asserted, tx_ready_n and rx_ready_n are 1, and tx_irq and rx_irq are 0. The block-mode transmit hold state also resets to 1 (not ready).
- R10: The mode_block encoding is 0 for single-character mode and 1 for block mode. Block mode takes effect only when fifo_en=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled (1) or single holding register (0) |
| mode_block | input | 1 | Handshake mode: 0 single-character, 1 block |
| tx_level | input | CW | Transmit FIFO occupancy, 0..DEPTH |
| rx_level | input | CW | Receive FIFO occupancy, 0..DEPTH |
| rx_trig | input | CW | Programmed receive trigger level |
| tx_ready_n | output | 1 | Active-low transmit DMA request |
| rx_ready_n | output | 1 | Active-low receive DMA request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

CW is $clog2(DEPTH+1).

## Verification
The bench targets four corner cases:

- **Transmit hysteresis in block mode.** The bench steps through partial fill levels after the FIFO has been empty, and again after it has been full. A design that decodes the level combinationally would release or assert tx_ready_n too early.
- **Trigger clamping.** The bench drives trigger values of zero and above DEPTH. A design without the clamp would either flag an empty FIFO or never assert rx_irq on a full one.
- **FIFO-enable override.** With fifo_en=0 and mode_block=1, a design that ignored the override would apply block rules to a one-byte holding register.
- **Latency and reset.** The bench samples before and after one edge to catch a combinational leak. It also checks that the hold state comes out of reset as not ready.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;
  typedef enum logic {
    HS_SINGLE = 1'b0,
    HS_BLOCK  = 1'b1
  } hs_mode_e;
endpackage

// File: rtl/dma_rdy_mode_sel.sv
module dma_rdy_mode_sel
  import dma_rdy_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          fifo_en,
  input  logic          mode_block,
  input  logic [CW-1:0] rx_trig,
  output hs_mode_e      eff_mode,
  output logic [CW-1:0] eff_depth,
  output logic [CW-1:0] eff_trig
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  always_comb begin
    // Disabled FIFOs collapse to a one-entry single-character holding stage.
    eff_mode  = (fifo_en && mode_block) ? HS_BLOCK : HS_SINGLE;
    eff_depth = fifo_en ? DEPTH_C : ONE_C;
    if (rx_trig == '0)          eff_trig = ONE_C;
    else if (rx_trig > DEPTH_C) eff_trig = DEPTH_C;
    else                        eff_trig = rx_trig;
  end
endmodule

// File: rtl/dma_rdy_tx.sv
module dma_rdy_tx
  import dma_rdy_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hs_mode_e      eff_mode,
  input  logic [CW-1:0] eff_depth,
  input  logic [CW-1:0] tx_level,
  output logic          tx_ready_n,
  output logic          tx_irq
);
  logic has_space, is_empty, is_full;
  logic rdy_n_d, irq_d;

  always_comb begin
    has_space = tx_level < eff_depth;
    is_empty  = tx_level == '0;
    is_full   = tx_level >= eff_depth;
    unique case (eff_mode)
      HS_BLOCK: begin
        // Hysteresis: assert when drained, release when full, else hold.
        if (is_empty)     rdy_n_d = 1'b0;
        else if (is_full) rdy_n_d = 1'b1;
        else              rdy_n_d = tx_ready_n;
        irq_d = is_empty;
      end
      default: begin
        rdy_n_d = !has_space;
        irq_d   = has_space;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ready_n <= 1'b1;
      tx_irq     <= 1'b0;
    end else begin
      tx_ready_n <= rdy_n_d;
      tx_irq     <= irq_d;
    end
  end
endmodule

// File: rtl/dma_rdy_rx.sv
module dma_rdy_rx
  import dma_rdy_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hs_mode_e      eff_mode,
  input  logic [CW-1:0] eff_trig,
  input  logic [CW-1:0] rx_level,
  output logic          rx_ready_n,
  output logic          rx_irq
);
  logic want;

  always_comb begin
    unique case (eff_mode)
      HS_BLOCK: want = rx_level >= eff_trig;
      default:  want = rx_level != '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ready_n <= 1'b1;
      rx_irq     <= 1'b0;
    end else begin
      rx_ready_n <= !want;
      rx_irq     <= want;
    end
  end
endmodule

// File: rtl/dma_ready_gen.sv
module dma_ready_gen
  import dma_rdy_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          mode_block,
  input  logic [CW-1:0] tx_level,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] rx_trig,
  output logic          tx_ready_n,
  output logic          rx_ready_n,
  output logic          tx_irq,
  output logic          rx_irq
);
  hs_mode_e      eff_mode;
  logic [CW-1:0] eff_depth;
  logic [CW-1:0] eff_trig;

  dma_rdy_mode_sel #(.DEPTH(DEPTH)) u_mode (
    .fifo_en    (fifo_en),
    .mode_block (mode_block),
    .rx_trig    (rx_trig),
    .eff_mode   (eff_mode),
    .eff_depth  (eff_depth),
    .eff_trig   (eff_trig)
  );

  dma_rdy_tx #(.DEPTH(DEPTH)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .eff_mode   (eff_mode),
    .eff_depth  (eff_depth),
    .tx_level   (tx_level),
    .tx_ready_n (tx_ready_n),
    .tx_irq     (tx_irq)
  );

  dma_rdy_rx #(.DEPTH(DEPTH)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .eff_mode   (eff_mode),
    .eff_trig   (eff_trig),
    .rx_level   (rx_level),
    .rx_ready_n (rx_ready_n),
    .rx_irq     (rx_irq)
  );
endmodule

// File: rtl/dma_ready_gen_chk.sv
module dma_ready_gen_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          mode_block,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic [CW-1:0] rx_trig,
  input logic          tx_ready_n,
  input logic          rx_ready_n,
  input logic          tx_irq,
  input logic          rx_irq
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  a_r1_single_tx_space: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !mode_block && tx_level < DEPTH_C) |=> (!tx_ready_n && tx_irq));

  a_r2_single_rx_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fifo_en && mode_block) && rx_level != '0) |=> (!rx_ready_n && rx_irq));

  a_r3_block_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && mode_block) |=> (tx_irq == $past(tx_level == '0)));

  a_r4_block_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && mode_block && tx_level != '0 && tx_level < DEPTH_C) |=> $stable(tx_ready_n));

  a_r5_block_rx_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && mode_block && rx_trig != '0 && rx_trig <= DEPTH_C && rx_level >= rx_trig)
    |=> (!rx_ready_n && rx_irq));

  a_r7_disabled_depth1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && tx_level != '0) |=> (tx_ready_n && !tx_irq));

  a_r9_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (tx_ready_n && rx_ready_n && !tx_irq && !rx_irq));
endmodule

bind dma_ready_gen dma_ready_gen_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_en    (fifo_en),
  .mode_block (mode_block),
  .tx_level   (tx_level),
  .rx_level   (rx_level),
  .rx_trig    (rx_trig),
  .tx_ready_n (tx_ready_n),
  .rx_ready_n (rx_ready_n),
  .tx_irq     (tx_irq),
  .rx_irq     (rx_irq)
);

// File: tb/dma_ready_gen_test.sv
`timescale 1ns/1ps
module dma_ready_gen_test;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic          en;
    logic          blk;
    logic [CW-1:0] txl;
    logic [CW-1:0] rxl;
    logic [CW-1:0] trg;
    logic [3:0]    exp;  // {tx_ready_n, rx_ready_n, tx_irq, rx_irq}
  } vec_t;

  localparam int NV = 15;
  // Order matters: the block-mode transmit hold state carries between rows.
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 5'd0,  5'd0,  5'd4,  4'b0110}, // R1 R2 empty, single
    '{1'b1, 1'b0, 5'd16, 5'd3,  5'd4,  4'b1001}, // R1 full tx, R2 data
    '{1'b1, 1'b0, 5'd15, 5'd1,  5'd4,  4'b0011}, // R1 one free slot
    '{1'b0, 1'b1, 5'd1,  5'd1,  5'd8,  4'b1001}, // R7 depth 1, mode ignored
    '{1'b0, 1'b0, 5'd0,  5'd0,  5'd8,  4'b0110}, // R7 empty holding reg
    '{1'b1, 1'b1, 5'd5,  5'd3,  5'd4,  4'b0100}, // R4 hold low, R5 below trig
    '{1'b1, 1'b1, 5'd16, 5'd4,  5'd4,  4'b1001}, // R4 full releases, R5 at trig
    '{1'b1, 1'b1, 5'd8,  5'd10, 5'd4,  4'b1001}, // R4 hold high, R5 past trig
    '{1'b1, 1'b1, 5'd0,  5'd16, 5'd4,  4'b0011}, // R3 empty irq, R5 full rx
    '{1'b1, 1'b1, 5'd3,  5'd0,  5'd0,  4'b0100}, // R6 trig 0 -> 1, empty
    '{1'b1, 1'b1, 5'd3,  5'd1,  5'd0,  4'b0001}, // R6 trig 0 -> 1, one byte
    '{1'b1, 1'b1, 5'd3,  5'd15, 5'd20, 4'b0100}, // R6 trig clamp to DEPTH
    '{1'b1, 1'b1, 5'd3,  5'd16, 5'd20, 4'b0001}, // R6 clamp reached
    '{1'b1, 1'b1, 5'd16, 5'd3,  5'd3,  4'b1001}, // R10 block mode
    '{1'b1, 1'b1, 5'd1,  5'd2,  5'd3,  4'b1100}  // R4 hold high near empty
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, mode_block = 1'b0;
  logic [CW-1:0] tx_level = '0, rx_level = '0, rx_trig = '0;
  logic tx_ready_n, rx_ready_n, tx_irq, rx_irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_ready_gen #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .mode_block(mode_block),
    .tx_level(tx_level), .rx_level(rx_level), .rx_trig(rx_trig),
    .tx_ready_n(tx_ready_n), .rx_ready_n(rx_ready_n),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {tx_ready_n, rx_ready_n, tx_irq, rx_irq};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic blk, input logic [CW-1:0] t,
                       input logic [CW-1:0] r, input logic [CW-1:0] g);
    fifo_en = en; mode_block = blk; tx_level = t; rx_level = r; rx_trig = g;
  endtask

  initial begin
    // R9: reset dominates non-idle inputs
    drive(1'b1, 1'b0, 5'd0, 5'd5, 5'd1);
    repeat (3) @(posedge clk);
    #1 check("R9 reset", 4'b1100);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].en, VECS[i].blk, VECS[i].txl, VECS[i].rxl, VECS[i].trg);
      @(posedge clk);
      #1 check($sformatf("R1-table row %0d", i), VECS[i].exp);
    end

    // R8: one-cycle latency
    @(negedge clk) drive(1'b1, 1'b0, 5'd0, 5'd0, 5'd4);
    @(posedge clk); #1 check("R8 settle", 4'b0110);
    @(negedge clk) drive(1'b1, 1'b0, 5'd16, 5'd2, 5'd4);
    #1 check("R8 before edge", 4'b0110);
    @(posedge clk); #1 check("R8 after edge", 4'b1001);

    // R9: hold state leaves reset high; block mode mid level keeps it high
    @(negedge clk) begin rst_n = 1'b0; drive(1'b1, 1'b1, 5'd5, 5'd0, 5'd4); end
    @(posedge clk); #1 check("R9 in reset", 4'b1100);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check("R9 hold after reset", 4'b1100);
    @(negedge clk) drive(1'b1, 1'b1, 5'd0, 5'd0, 5'd4);
    @(posedge clk); #1 check("R3 drained", 4'b0110);
    @(negedge clk) drive(1'b1, 1'b1, 5'd15, 5'd0, 5'd4);
    @(posedge clk); #1 check("R4 hold at 15", 4'b0100);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule